// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a byte-wide parallel NOR-style flash controller. It watches a host write bus, which has a 20-bit address, an 8-bit data byte and an active-low write strobe. The strobe is brought into the system clock domain and its edges are detected there. The address is taken when the strobe falls. The data is taken when the strobe rises, and that write is then decoded.

Multi-cycle sequences start with an unlock pair and end with a command byte. The decoder walks through these sequences, reports the current operating mode and raises single-cycle requests towards an external operation engine. Each request carries the operands it needs: the program address and byte, or the 4-bit sector number. A busy input from the engine keeps program and chip erase from being disturbed. When busy falls, the block returns to read mode.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After the asynchronous active-low reset, mode_o is 0 (read) and no request is raised. Any partially entered sequence is discarded, so the next write must start a fresh unlock pair.
- R2: The writes 0xAA, 0x55, 0x90 set mode_o to 1 (autoselect) and raise no request.
- R3: The writes 0xAA, 0x55, 0xA0 followed by a fourth write raise prog_req_o for one cycle. prog_addr_o holds the fourth write's address and prog_data_o holds its byte. Any byte value, 0xF0 included, is taken as program data. mode_o becomes 2 (program).
- R4: The writes 0xAA, 0x55, 0x80, 0xAA, 0x55, 0x10 raise chip_erase_req_o for one cycle and set mode_o to 3 (chip erase).
- R5: The same erase prefix followed by 0x30 raises sector_erase_req_o for one cycle. sector_o holds address bits 19..16 of that sixth write, and mode_o becomes 4 (sector erase).
- R6: A write of 0xF0 in any position other than the program-data write sets mode_o to 0 and restarts decoding. This holds even while busy_i is high. The sequence 0xAA, 0x55, 0xF0 has the same effect.
- R7: A write whose byte does not fit its position in a sequence sets mode_o to 0 and restarts decoding at the first unlock write.
- R8: In mode 4, 0xB0 raises suspend_req_o and sets mode 5 (suspended). In mode 5, 0x30 raises resume_req_o and sets mode 4. In modes 4 and 5 any other byte except 0xF0 sets mode 0. Outside modes 4 and 5, a lone 0xB0 or 0x30 is invalid: mode becomes 0 and no request is raised.
- R9: The address is the value present on addr_i when the strobe falls. The data is the value present on data_i when the strobe rises. Changes while the strobe is low have no effect.
- R10: While busy_i is high in mode 2 or 3, every write other than 0xF0 is ignored: mode_o is unchanged and no request is raised.
- R11: When busy_i falls in mode 2, 3 or 4, mode_o returns to 0. In mode 5, a falling busy_i has no effect.
- R12: Each request is a one-cycle pulse, and at most one request is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 20 | Host address |
| data_i | input | 8 | Host write data |
| we_ni | input | 1 | Active-low write strobe, asynchronous to clk_i |
| busy_i | input | 1 | Operation engine busy |
| mode_o | output | 3 | Current mode: 0 read, 1 autoselect, 2 program, 3 chip erase, 4 sector erase, 5 suspended |
| prog_req_o | output | 1 | Program request pulse |
| prog_addr_o | output | 20 | Program target address |
| prog_data_o | output | 8 | Program data byte |
| chip_erase_req_o | output | 1 | Chip erase request pulse |
| sector_erase_req_o | output | 1 | Sector erase request pulse |
| sector_o | output | 4 | Sector number for the sector erase request |
| suspend_req_o | output | 1 | Erase suspend request pulse |
| resume_req_o | output | 1 | Erase resume request pulse |

## Verification
The assertions check the following on every cycle:
- requests are exclusive and last one cycle;
- every request agrees with the mode it enters;
- a suspend is only ever raised from sector erase;
- a lone 0xF0 always lands in read mode;
- busy-blocked writes leave the mode untouched;
- a decode event always follows a strobe rise.

Only the bench's scenarios can show the rest:
- the full grammar, including aborts on wrong bytes and wrong positions;
- the rejection of suspend and resume outside an erase;
- the address and data being taken from opposite strobe edges;
- the return to read when busy falls.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [2:0] {
    MODE_READ         = 3'd0,
    MODE_AUTOSEL      = 3'd1,
    MODE_PROGRAM      = 3'd2,
    MODE_CHIP_ERASE   = 3'd3,
    MODE_SECTOR_ERASE = 3'd4,
    MODE_SUSPENDED    = 3'd5
  } mode_e;

  typedef enum logic [2:0] {
    SEQ_UNLOCK1,
    SEQ_UNLOCK2,
    SEQ_CMD,
    SEQ_PROG_DATA,
    SEQ_ER_UNLOCK1,
    SEQ_ER_UNLOCK2,
    SEQ_ER_CMD
  } seq_e;

  localparam logic [7:0] BYTE_UNLOCK1  = 8'hAA;
  localparam logic [7:0] BYTE_UNLOCK2  = 8'h55;
  localparam logic [7:0] BYTE_RESET    = 8'hF0;
  localparam logic [7:0] BYTE_AUTOSEL  = 8'h90;
  localparam logic [7:0] BYTE_PROGRAM  = 8'hA0;
  localparam logic [7:0] BYTE_ERASE    = 8'h80;
  localparam logic [7:0] BYTE_CHIP     = 8'h10;
  localparam logic [7:0] BYTE_SECTOR   = 8'h30;
  localparam logic [7:0] BYTE_SUSPEND  = 8'hB0;
  localparam logic [7:0] BYTE_RESUME   = 8'h30;
endpackage

// File: rtl/fcd_strobe_sync.sv
module fcd_strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_ni,
  output logic fall_o,
  output logic rise_o
);
  localparam int TOP = SYNC_STAGES;

  logic [TOP:0] sh_q;

  // stage 0 samples the asynchronous strobe; idle level is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[TOP-1:0], we_ni};
  end

  assign fall_o = sh_q[TOP] & ~sh_q[TOP-1];
  assign rise_o = ~sh_q[TOP] & sh_q[TOP-1];
endmodule

// File: rtl/fcd_bus_capture.sv
module fcd_bus_capture #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              rise_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              evt_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      data_o <= '0;
      evt_o  <= 1'b0;
    end else begin
      if (fall_i) addr_o <= addr_i;
      if (rise_i) data_o <= data_i;
      evt_o <= rise_i;
    end
  end

  p_evt_after_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> $past(rise_i));
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 8,
  parameter int SECTOR_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                evt_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic                busy_i,
  output mode_e               mode_o,
  output logic                prog_req_o,
  output logic [ADDR_W-1:0]   prog_addr_o,
  output logic [DATA_W-1:0]   prog_data_o,
  output logic                chip_req_o,
  output logic                sect_req_o,
  output logic [SECTOR_W-1:0] sector_o,
  output logic                susp_req_o,
  output logic                res_req_o
);
  localparam int SECT_LSB = ADDR_W - SECTOR_W;

  mode_e mode_q, mode_d;
  seq_e  seq_q, seq_d;
  logic  busy_q;
  logic  prog_d, chip_d, sect_d, susp_d, res_d;
  logic [7:0] cmd;
  logic  blocked, erase_live, busy_fall;

  assign cmd        = data_i[7:0];
  assign blocked    = busy_i && (mode_q == MODE_PROGRAM || mode_q == MODE_CHIP_ERASE);
  assign erase_live = (mode_q == MODE_SECTOR_ERASE) || (mode_q == MODE_SUSPENDED);
  assign busy_fall  = busy_q & ~busy_i;

  always_comb begin
    mode_d = mode_q;
    seq_d  = seq_q;
    prog_d = 1'b0;
    chip_d = 1'b0;
    sect_d = 1'b0;
    susp_d = 1'b0;
    res_d  = 1'b0;
    if (evt_i) begin
      if (cmd == BYTE_RESET && seq_q != SEQ_PROG_DATA) begin
        mode_d = MODE_READ;
        seq_d  = SEQ_UNLOCK1;
      end else if (blocked) begin
        // engine running: hold everything
      end else if (erase_live) begin
        seq_d = SEQ_UNLOCK1;
        if (cmd == BYTE_SUSPEND) begin
          if (mode_q == MODE_SECTOR_ERASE) begin
            mode_d = MODE_SUSPENDED;
            susp_d = 1'b1;
          end
        end else if (cmd == BYTE_RESUME) begin
          if (mode_q == MODE_SUSPENDED) begin
            mode_d = MODE_SECTOR_ERASE;
            res_d  = 1'b1;
          end
        end else begin
          mode_d = MODE_READ;
        end
      end else begin
        // default: abort to read unless a step matches
        mode_d = MODE_READ;
        seq_d  = SEQ_UNLOCK1;
        unique case (seq_q)
          SEQ_UNLOCK1: if (cmd == BYTE_UNLOCK1) begin
            mode_d = mode_q;
            seq_d  = SEQ_UNLOCK2;
          end
          SEQ_UNLOCK2: if (cmd == BYTE_UNLOCK2) begin
            mode_d = mode_q;
            seq_d  = SEQ_CMD;
          end
          SEQ_CMD: begin
            if (cmd == BYTE_AUTOSEL) begin
              mode_d = MODE_AUTOSEL;
            end else if (cmd == BYTE_PROGRAM) begin
              mode_d = mode_q;
              seq_d  = SEQ_PROG_DATA;
            end else if (cmd == BYTE_ERASE) begin
              mode_d = mode_q;
              seq_d  = SEQ_ER_UNLOCK1;
            end
          end
          SEQ_PROG_DATA: begin
            mode_d = MODE_PROGRAM;
            prog_d = 1'b1;
          end
          SEQ_ER_UNLOCK1: if (cmd == BYTE_UNLOCK1) begin
            mode_d = mode_q;
            seq_d  = SEQ_ER_UNLOCK2;
          end
          SEQ_ER_UNLOCK2: if (cmd == BYTE_UNLOCK2) begin
            mode_d = mode_q;
            seq_d  = SEQ_ER_CMD;
          end
          SEQ_ER_CMD: begin
            if (cmd == BYTE_CHIP) begin
              mode_d = MODE_CHIP_ERASE;
              chip_d = 1'b1;
            end else if (cmd == BYTE_SECTOR) begin
              mode_d = MODE_SECTOR_ERASE;
              sect_d = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end else if (busy_fall && (mode_q == MODE_PROGRAM || mode_q == MODE_CHIP_ERASE ||
                               mode_q == MODE_SECTOR_ERASE)) begin
      mode_d = MODE_READ;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= MODE_READ;
      seq_q       <= SEQ_UNLOCK1;
      busy_q      <= 1'b0;
      prog_req_o  <= 1'b0;
      chip_req_o  <= 1'b0;
      sect_req_o  <= 1'b0;
      susp_req_o  <= 1'b0;
      res_req_o   <= 1'b0;
      prog_addr_o <= '0;
      prog_data_o <= '0;
      sector_o    <= '0;
    end else begin
      mode_q     <= mode_d;
      seq_q      <= seq_d;
      busy_q     <= busy_i;
      prog_req_o <= prog_d;
      chip_req_o <= chip_d;
      sect_req_o <= sect_d;
      susp_req_o <= susp_d;
      res_req_o  <= res_d;
      if (prog_d) begin
        prog_addr_o <= addr_i;
        prog_data_o <= data_i;
      end
      if (sect_d) sector_o <= addr_i[ADDR_W-1:SECT_LSB];
    end
  end

  assign mode_o = mode_q;

  p_req_onehot_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_req_o, chip_req_o, sect_req_o, susp_req_o, res_req_o}));
  p_prog_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |=> !prog_req_o);
  p_prog_mode_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |-> mode_q == MODE_PROGRAM);
  p_sector_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sect_req_o |-> mode_q == MODE_SECTOR_ERASE);
  p_suspend_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_req_o |-> ($past(mode_q) == MODE_SECTOR_ERASE) && (mode_q == MODE_SUSPENDED));
  p_reset_byte_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && cmd == BYTE_RESET && seq_q != SEQ_PROG_DATA) |=> mode_q == MODE_READ);
  p_busy_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && busy_i && cmd != BYTE_RESET &&
     (mode_q == MODE_PROGRAM || mode_q == MODE_CHIP_ERASE))
    |=> $stable(mode_q) && !prog_req_o && !chip_req_o && !sect_req_o);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 8,
  parameter int SECTOR_W    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic                we_ni,
  input  logic                busy_i,
  output logic [2:0]          mode_o,
  output logic                prog_req_o,
  output logic [ADDR_W-1:0]   prog_addr_o,
  output logic [DATA_W-1:0]   prog_data_o,
  output logic                chip_erase_req_o,
  output logic                sector_erase_req_o,
  output logic [SECTOR_W-1:0] sector_o,
  output logic                suspend_req_o,
  output logic                resume_req_o
);
  logic              fall, rise, evt;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  fcd_pkg::mode_e    mode;

  fcd_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_ni (we_ni),
    .fall_o(fall),
    .rise_o(rise)
  );

  fcd_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fall_i(fall),
    .rise_i(rise),
    .addr_i(addr_i),
    .data_i(data_i),
    .evt_o (evt),
    .addr_o(cap_addr),
    .data_o(cap_data)
  );

  fcd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECTOR_W(SECTOR_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .addr_i     (cap_addr),
    .data_i     (cap_data),
    .busy_i     (busy_i),
    .mode_o     (mode),
    .prog_req_o (prog_req_o),
    .prog_addr_o(prog_addr_o),
    .prog_data_o(prog_data_o),
    .chip_req_o (chip_erase_req_o),
    .sect_req_o (sector_erase_req_o),
    .sector_o   (sector_o),
    .susp_req_o (suspend_req_o),
    .res_req_o  (resume_req_o)
  );

  assign mode_o = mode;
endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
  localparam int K_PROG = 0, K_CHIP = 1, K_SECT = 2, K_SUSP = 3, K_RES = 4;

  typedef struct {
    int         kind;
    logic [19:0] a;
    logic [7:0]  d;
    logic [3:0]  s;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic [7:0]  data = '0;
  logic        we_n = 1'b1;
  logic        busy = 1'b0;
  logic [2:0]  mode;
  logic        prog_req, chip_req, sect_req, susp_req, res_req;
  logic [19:0] prog_addr;
  logic [7:0]  prog_data;
  logic [3:0]  sector;

  int   checks = 0;
  int   fails  = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  flash_cmd_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(data), .we_ni(we_n),
    .busy_i(busy), .mode_o(mode), .prog_req_o(prog_req), .prog_addr_o(prog_addr),
    .prog_data_o(prog_data), .chip_erase_req_o(chip_req),
    .sector_erase_req_o(sect_req), .sector_o(sector),
    .suspend_req_o(susp_req), .resume_req_o(res_req)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input int kind, input logic [19:0] a, input logic [7:0] d,
                      input logic [3:0] s, input string tag);
    exp_t e;
    e.kind = kind; e.a = a; e.d = d; e.s = s; e.tag = tag;
    q.push_back(e);
  endtask

  // address valid at strobe fall, data valid only at strobe rise (R9)
  task automatic bus_write(input logic [19:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; data = ~d; we_n = 1'b0;
    repeat (5) @(negedge clk);
    addr = ~a; data = d;
    repeat (3) @(negedge clk);
    we_n = 1'b1;
    repeat (5) @(negedge clk);
    data = ~d; addr = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_mode(input logic [2:0] m, input string tag);
    @(negedge clk);
    check(mode == m, tag, mode, m);
  endtask

  task automatic expect_drained(input string tag);
    @(negedge clk);
    check(q.size() == 0, tag, q.size(), 0);
  endtask

  // monitor: compares every request pulse against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      int k;
      k = -1;
      if (prog_req) k = K_PROG;
      if (chip_req) k = K_CHIP;
      if (sect_req) k = K_SECT;
      if (susp_req) k = K_SUSP;
      if (res_req)  k = K_RES;
      check($countones({prog_req, chip_req, sect_req, susp_req, res_req}) <= 1,
            "R12 onehot", {prog_req, chip_req, sect_req, susp_req, res_req}, 0);
      if (k >= 0) begin
        if (q.size() == 0) begin
          check(1'b0, "R12 unexpected request", k, -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(k == e.kind, e.tag, k, e.kind);
          if (e.kind == K_PROG) begin
            check(prog_addr == e.a, {e.tag, " addr R9"}, prog_addr, e.a);
            check(prog_data == e.d, {e.tag, " data R9"}, prog_data, e.d);
          end
          if (e.kind == K_SECT) check(sector == e.s, {e.tag, " sector"}, sector, e.s);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_mode(3'd0, "R1 reset mode");
    check(!(prog_req | chip_req | sect_req | susp_req | res_req), "R1 no request", 1, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_mode(3'd0, "R1 read after release");

    // R2 autoselect
    bus_write(20'h00555, 8'hAA);
    bus_write(20'h002AA, 8'h55);
    bus_write(20'h00555, 8'h90);
    expect_mode(3'd1, "R2 autoselect");

    // R6 three-cycle reset
    bus_write(20'h0, 8'hAA);
    bus_write(20'h0, 8'h55);
    bus_write(20'h0, 8'hF0);
    expect_mode(3'd0, "R6 three-cycle reset");

    // R3 program, then R10 busy hold, R11 completion
    bus_write(20'h0, 8'hAA);
    bus_write(20'h0, 8'h55);
    bus_write(20'h0, 8'hA0);
    push(K_PROG, 20'h12345, 8'h5A, 4'h0, "R3 program");
    bus_write(20'h12345, 8'h5A);
    expect_mode(3'd2, "R3 program mode");
    expect_drained("R3 program issued");
    busy = 1'b1;
    bus_write(20'h0, 8'hAA);
    bus_write(20'h0, 8'h55);
    bus_write(20'h0, 8'h90);
    expect_mode(3'd2, "R10 writes ignored while busy");
    busy = 1'b0;
    repeat (3) @(negedge clk);
    expect_mode(3'd0, "R11 program done");

    // R3 data byte 0xF0 is programmed, not a reset
    bus_write(20'h0, 8'hAA);
    bus_write(20'h0, 8'h55);
    bus_write(20'h0, 8'hA0);
    push(K_PROG, 20'h00F0F, 8'hF0, 4'h0, "R3 program F0 data");
    bus_write(20'h00F0F, 8'hF0);
    expect_mode(3'd2, "R3 F0 data mode");
    busy = 1'b1;
    repeat (3) @(negedge clk);
    busy = 1'b0;
    repeat (3) @(negedge clk);
    expect_mode(3'd0, "R11 second program done");

    // R4 chip erase, R6 reset while busy
    bus_write(20'h0, 8'hAA);
    bus_write(20'h0, 8'h55);
    bus_write(20'h0, 8'h80);
    bus_write(20'h0, 8'hAA);
    bus_write(20'h0, 8'h55);
    push(K_CHIP, 20'h0, 8'h0, 4'h0, "R4 chip erase");
    bus_write(20'h0, 8'h10);
    expect_mode(3'd3, "R4 chip erase mode");
    busy = 1'b1;
    bus_write(20'h0, 8'h30);
    expect_mode(3'd3, "R10 chip erase holds");
    bus_write(20'h0, 8'hF0);
    expect_mode(3'd0, "R6 reset while busy");
    busy = 1'b0;
    repeat (3) @(negedge clk);
    expect_mode(3'd0, "R11 fall in read mode");

    // R5 sector erase, R8 suspend/resume
    bus_write(20'h0, 8'hAA);
    bus_write(20'h0, 8'h55);
    bus_write(20'h0, 8'h80);
    bus_write(20'h0, 8'hAA);
    bus_write(20'h0, 8'h55);
    push(K_SECT, 20'h0, 8'h0, 4'hA, "R5 sector erase");
    bus_write(20'hA1234, 8'h30);
    expect_mode(3'd4, "R5 sector mode");
    busy = 1'b1;
    push(K_SUSP, 20'h0, 8'h0, 4'h0, "R8 suspend");
    bus_write(20'h0, 8'hB0);
    expect_mode(3'd5, "R8 suspended mode");
    busy = 1'b0;
    repeat (3) @(negedge clk);
    expect_mode(3'd5, "R11 no exit when suspended");
    busy = 1'b1;
    push(K_RES, 20'h0, 8'h0, 4'h0, "R8 resume");
    bus_write(20'h0, 8'h30);
    expect_mode(3'd4, "R8 resumed mode");
    busy = 1'b0;
    repeat (3) @(negedge clk);
    expect_mode(3'd0, "R11 sector erase done");
    expect_drained("R8 requests issued");

    // R8 suspend/resume outside an erase are invalid
    bus_write(20'h0, 8'hAA);
    bus_write(20'h0, 8'h55);
    bus_write(20'h0, 8'h90);
    bus_write(20'h0, 8'hB0);
    expect_mode(3'd0, "R8 suspend rejected");
    bus_write(20'h0, 8'h30);
    expect_mode(3'd0, "R8 resume rejected");

    // R7 bad command byte and bad position
    bus_write(20'h0, 8'hAA);
    bus_write(20'h0, 8'h55);
    bus_write(20'h0, 8'h77);
    expect_mode(3'd0, "R7 bad command");
    bus_write(20'h0, 8'hAA);
    bus_write(20'h0, 8'hAA);
    bus_write(20'h0, 8'h55);
    bus_write(20'h0, 8'h90);
    expect_mode(3'd0, "R7 bad position restarts");
    bus_write(20'h0, 8'hAA);
    bus_write(20'h0, 8'h55);
    bus_write(20'h0, 8'h90);
    expect_mode(3'd1, "R7 clean sequence after abort");
    bus_write(20'h0, 8'h12);
    expect_mode(3'd0, "R7 abort from autoselect");

    // R6 lone F0 mid-sequence
    bus_write(20'h0, 8'hAA);
    bus_write(20'h0, 8'hF0);
    bus_write(20'h0, 8'h55);
    bus_write(20'h0, 8'h90);
    expect_mode(3'd0, "R6 lone reset mid-sequence");

    // R1 reset clears partial sequence
    bus_write(20'h0, 8'hAA);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    bus_write(20'h0, 8'h55);
    bus_write(20'h0, 8'h90);
    expect_mode(3'd0, "R1 partial sequence cleared");

    expect_drained("R12 scoreboard empty");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule